// File: doc/BRIEF.md
# System Control Register Bank

This block holds the privileged control registers of a 32-bit RISC core. The pipeline picks a register with a 5-bit number and a 3-bit select and either writes it or reads it back. A write is not plain storage. Each register keeps only its writable bits, and fixed fields keep their value. Some writes also cause a side effect: an address-space change raises a translation-flush pulse, and some writes ask for interrupt re-evaluation.

The same bank also carries out the exception-return sequence and the atomic interrupt disable and enable operations, which hand back the old status word. It also gates user reads of a small set of hardware values on a per-value enable. Mode flags (user, error level, exception level) leave the block as registered outputs, so the core can use them directly.

One operation is issued per cycle on `op`. Every output is registered: a result appears one clock after the operation is presented. `rd_data` always shows the register addressed in the previous cycle, with the value it held before any write in that same cycle.

Top module: `sysctl_regfile`

## Requirements
- R1: After synchronous reset, the status view reads 0x00000004 (error-level flag set, all else clear), and `mode_erl` is 1 while `mode_um` and `mode_exl` are 0. The base register (15,1) reads 0x80000000, and every other register reads zero.
- R2: The addressed register's value before the current cycle's update appears on `rd_data` one cycle after `reg_num`/`reg_sel` are presented.
  - A write is `op`=1.
  - The TLB index register (0,0) keeps its bit 31 and takes only `wr_data & (TLB_ENTRIES-1)` in its low bits.
- R3: Writes to the two page-entry registers (2,0) and (3,0) keep `wr_data & 0x3FFFFFFF`. A write to the page-size register (5,0) keeps `wr_data & 0x1FFFE000`.
- R4: A write to the context register (4,0) replaces bits 22:4 only. Bits 31:23 keep their old value and bits 3:0 become zero.
- R5: A status write (12,0) stores `wr_data & 0xFA78FF01`. It also loads `mode_um`, `mode_erl` and `mode_exl` from data bits 4, 2 and 1, and pulses `irq_update`. A status read returns the stored word OR'd with the three mode flags at bits 4, 2 and 1.
- R6: A cause write (13,0) changes only the bits in 0x00C00300 and keeps the bits in 0xB000F87C. It pulses `irq_update` only if data bit 8 or 9 (software interrupts) is set.
- R7: Base writes (15,1) read back as `0x80000000 | (wr_data & 0x3FFFF000)`. The hardware-read enable register (7,0) keeps bits 3:0 only. Registers (12,1), (12,2) and (12,3) always read zero, even after a write.
- R8: An address-space write (10,0) stores the data with bits 12:8 cleared. It pulses `asid_flush` exactly when bits 7:0 differ from the old value.
- R9: Exception return is `op`=2.
  - If `mode_erl` is set, `ret_pc` gets the error return register (30,0) and `mode_erl` clears.
  - Otherwise, `ret_pc` gets the exception return register (14,0) and `mode_exl` clears.
  - Either way, `ret_valid` pulses and the link address is set to 1.
- R10: Interrupt disable (`op`=3) and enable (`op`=4) put the prior status view on `old_status`, clear or set status bit 0, and pulse `irq_update`.
- R11: A hardware read (`op`=5) selects its value with `hw_idx`: 0 is the CPU number (`base & 0x2FF`), 1 is SYNCI_STEP, 2 is `cycle_cnt`, and 3 is CC_RES.
  - The read succeeds only when enable bit `hw_idx` is set.
  - Otherwise `hw_ri` pulses and `hw_data` is zero.
- R12: `ll_load` captures `ll_addr` into the link address. Reading register (17,0) returns that address shifted right by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation: 0 none, 1 write, 2 exception return, 3 disable, 4 enable, 5 hardware read |
| reg_num | input | 5 | Register number |
| reg_sel | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| hw_idx | input | 2 | Hardware value index for op 5 |
| cycle_cnt | input | 32 | Cycle counter value from the timer |
| ll_load | input | 1 | Capture a link address |
| ll_addr | input | 32 | Link address to capture |
| rd_data | output | 32 | Registered read data |
| ret_pc | output | 32 | Exception return target |
| ret_valid | output | 1 | Pulse: ret_pc is valid |
| old_status | output | 32 | Status view before disable/enable |
| hw_data | output | 32 | Hardware read result |
| hw_ri | output | 1 | Pulse: hardware read refused |
| mode_um | output | 1 | User mode flag |
| mode_erl | output | 1 | Error level flag |
| mode_exl | output | 1 | Exception level flag |
| asid_flush | output | 1 | Pulse: address-space identifier changed |
| irq_update | output | 1 | Pulse: re-evaluate interrupts |

## Verification
The hardest state to reach is the second branch of exception return: the error-level flag clear while the exception-level flag is still set. Reset leaves the error-level flag set. The stimulus therefore writes status with both flags set, runs one return to clear the error level, and checks that the error return address was used. A second return must then use the exception return address. The translation-flush pulse also needs a repeated write with an unchanged identifier, so that the pulse is shown to stay low.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int NREG = 16;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_MOVE_TO = 3'd1,
    OP_ERET    = 3'd2,
    OP_IDIS    = 3'd3,
    OP_IEN     = 3'd4,
    OP_HWREAD  = 3'd5
  } sc_op_e;

  // register slot numbers inside the bank
  localparam int S_IDX   = 0;
  localparam int S_ELO0  = 1;
  localparam int S_ELO1  = 2;
  localparam int S_CTX   = 3;
  localparam int S_PMASK = 4;
  localparam int S_HWEN  = 5;
  localparam int S_EHI   = 6;
  localparam int S_STAT  = 7;
  localparam int S_ICTL  = 8;
  localparam int S_SRSC  = 9;
  localparam int S_SRSM  = 10;
  localparam int S_CAUSE = 11;
  localparam int S_EPC   = 12;
  localparam int S_EBASE = 13;
  localparam int S_LLA   = 14;
  localparam int S_EEPC  = 15;

  // {number, select} address for each slot, decoded by the pipeline
  localparam logic [7:0] SLOT_ADDR [NREG] = '{
    8'h00, 8'h10, 8'h18, 8'h20, 8'h28, 8'h38, 8'h50, 8'h60,
    8'h61, 8'h62, 8'h63, 8'h68, 8'h70, 8'h79, 8'h88, 8'hF0
  };

  localparam logic [31:0] M_ELO     = 32'h3FFF_FFFF;
  localparam logic [31:0] M_PMASK   = 32'h1FFF_E000;
  localparam logic [31:0] M_CTX_WR  = 32'h007F_FFF0;
  localparam logic [31:0] M_CTX_KP  = 32'hFF80_0000;
  localparam logic [31:0] M_STAT    = 32'hFA78_FF01;
  localparam logic [31:0] M_CAU_WR  = 32'h00C0_0300;
  localparam logic [31:0] M_CAU_KP  = 32'hB000_F87C;
  localparam logic [31:0] M_EBASE   = 32'h3FFF_F000;
  localparam logic [31:0] EBASE_FIX = 32'h8000_0000;
  localparam logic [31:0] M_EHI_CLR = 32'h0000_1F00;
  localparam logic [31:0] M_CPUNUM  = 32'h0000_02FF;

  localparam int B_IE  = 0;
  localparam int B_EXL = 1;
  localparam int B_ERL = 2;
  localparam int B_UM  = 4;

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
  import sysctl_pkg::*;
(
  input  logic [4:0]      num,
  input  logic [2:0]      sel,
  output logic [NREG-1:0] hit
);
  logic [7:0] code;
  assign code = {num, sel};

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    assign hit[i] = (code == SLOT_ADDR[i]);
  end
endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux #(
  parameter int N = 16,
  parameter int W = 32
) (
  input  logic [N-1:0]        hit,
  input  logic [N-1:0][W-1:0] view,
  output logic [W-1:0]        dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) dout = dout | view[i];
    end
  end
endmodule

// File: rtl/sysctl_hwr_gate.sv
module sysctl_hwr_gate #(
  parameter logic [31:0] SYNCI_STEP = 32'd32,
  parameter logic [31:0] CC_RES     = 32'd2
) (
  input  logic [3:0]  enable,
  input  logic [1:0]  idx,
  input  logic [31:0] cpu_num,
  input  logic [31:0] cycles,
  output logic        allow,
  output logic [31:0] value
);
  logic [31:0] src;
  always_comb begin
    case (idx)
      2'd0:    src = cpu_num;
      2'd1:    src = SYNCI_STEP;
      2'd2:    src = cycles;
      default: src = CC_RES;
    endcase
  end
  assign allow = enable[idx];
  assign value = allow ? src : 32'd0;
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int          TLB_ENTRIES = 16,
  parameter logic [31:0] SYNCI_STEP  = 32'd32,
  parameter logic [31:0] CC_RES      = 32'd2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  op,
  input  logic [4:0]  reg_num,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  hw_idx,
  input  logic [31:0] cycle_cnt,
  input  logic        ll_load,
  input  logic [31:0] ll_addr,
  output logic [31:0] rd_data,
  output logic [31:0] ret_pc,
  output logic        ret_valid,
  output logic [31:0] old_status,
  output logic [31:0] hw_data,
  output logic        hw_ri,
  output logic        mode_um,
  output logic        mode_erl,
  output logic        mode_exl,
  output logic        asid_flush,
  output logic        irq_update
);
  localparam logic [31:0] M_IDX = 32'(TLB_ENTRIES - 1);

  sc_op_e cur_op;
  assign cur_op = sc_op_e'(op);

  logic [31:0] idx_q, elo0_q, elo1_q, ctx_q, pmask_q, ehi_q, stat_q;
  logic [31:0] cause_q, epc_q, ebase_q, lla_q, eepc_q;
  logic [3:0]  hwen_q;

  logic [NREG-1:0]        hit;
  logic [NREG-1:0][31:0]  view;
  logic [31:0]            rd_val, stat_view;
  logic                   hw_ok;
  logic [31:0]            hw_val;

  assign stat_view = stat_q | (32'(mode_um) << B_UM) | (32'(mode_erl) << B_ERL)
                   | (32'(mode_exl) << B_EXL);

  always_comb begin
    view          = '0;
    view[S_IDX]   = idx_q;
    view[S_ELO0]  = elo0_q;
    view[S_ELO1]  = elo1_q;
    view[S_CTX]   = ctx_q;
    view[S_PMASK] = pmask_q;
    view[S_HWEN]  = {28'd0, hwen_q};
    view[S_EHI]   = ehi_q;
    view[S_STAT]  = stat_view;
    view[S_CAUSE] = cause_q;
    view[S_EPC]   = epc_q;
    view[S_EBASE] = ebase_q;
    view[S_LLA]   = lla_q >> 4;
    view[S_EEPC]  = eepc_q;
  end

  sysctl_addr_dec u_dec (
    .num (reg_num),
    .sel (reg_sel),
    .hit (hit)
  );

  sysctl_rd_mux #(.N(NREG), .W(32)) u_mux (
    .hit  (hit),
    .view (view),
    .dout (rd_val)
  );

  sysctl_hwr_gate #(.SYNCI_STEP(SYNCI_STEP), .CC_RES(CC_RES)) u_hwr (
    .enable  (hwen_q),
    .idx     (hw_idx),
    .cpu_num (ebase_q & M_CPUNUM),
    .cycles  (cycle_cnt),
    .allow   (hw_ok),
    .value   (hw_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0; elo0_q <= '0; elo1_q <= '0; ctx_q <= '0; pmask_q <= '0;
      ehi_q <= '0; stat_q <= '0; cause_q <= '0; epc_q <= '0; lla_q <= '0;
      eepc_q <= '0; hwen_q <= '0;
      ebase_q    <= EBASE_FIX;
      mode_um    <= 1'b0;
      mode_erl   <= 1'b1;
      mode_exl   <= 1'b0;
      rd_data    <= '0;
      ret_pc     <= '0;
      ret_valid  <= 1'b0;
      old_status <= '0;
      hw_data    <= '0;
      hw_ri      <= 1'b0;
      asid_flush <= 1'b0;
      irq_update <= 1'b0;
    end else begin
      rd_data    <= rd_val;
      ret_valid  <= 1'b0;
      hw_ri      <= 1'b0;
      asid_flush <= 1'b0;
      irq_update <= 1'b0;
      if (ll_load) lla_q <= ll_addr;
      case (cur_op)
        OP_MOVE_TO: begin
          if (hit[S_IDX])   idx_q   <= (idx_q & 32'h8000_0000) | (wr_data & M_IDX);
          if (hit[S_ELO0])  elo0_q  <= wr_data & M_ELO;
          if (hit[S_ELO1])  elo1_q  <= wr_data & M_ELO;
          if (hit[S_CTX])   ctx_q   <= (ctx_q & M_CTX_KP) | (wr_data & M_CTX_WR);
          if (hit[S_PMASK]) pmask_q <= wr_data & M_PMASK;
          if (hit[S_HWEN])  hwen_q  <= wr_data[3:0];
          if (hit[S_EHI]) begin
            ehi_q      <= wr_data & ~M_EHI_CLR;
            asid_flush <= (ehi_q[7:0] != wr_data[7:0]);
          end
          if (hit[S_STAT]) begin
            stat_q     <= wr_data & M_STAT;
            mode_um    <= wr_data[B_UM];
            mode_erl   <= wr_data[B_ERL];
            mode_exl   <= wr_data[B_EXL];
            irq_update <= 1'b1;
          end
          if (hit[S_CAUSE]) begin
            cause_q    <= (cause_q & M_CAU_KP) | (wr_data & M_CAU_WR);
            irq_update <= |wr_data[9:8];
          end
          if (hit[S_EPC])   epc_q   <= wr_data;
          if (hit[S_EBASE]) ebase_q <= EBASE_FIX | (wr_data & M_EBASE);
          if (hit[S_EEPC])  eepc_q  <= wr_data;
        end
        OP_ERET: begin
          if (mode_erl) begin
            ret_pc   <= eepc_q;
            mode_erl <= 1'b0;
          end else begin
            ret_pc   <= epc_q;
            mode_exl <= 1'b0;
          end
          ret_valid <= 1'b1;
          lla_q     <= 32'd1;
        end
        OP_IDIS: begin
          old_status   <= stat_view;
          stat_q[B_IE] <= 1'b0;
          irq_update   <= 1'b1;
        end
        OP_IEN: begin
          old_status   <= stat_view;
          stat_q[B_IE] <= 1'b1;
          irq_update   <= 1'b1;
        end
        OP_HWREAD: begin
          hw_data <= hw_val;
          hw_ri   <= ~hw_ok;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] op,
  input logic       ret_valid,
  input logic       hw_ri,
  input logic       mode_erl,
  input logic       mode_exl,
  input logic       asid_flush,
  input logic       irq_update
);
  // R1
  reset_erl_chk: assert property (@(posedge clk) $past(rst) && !rst |-> mode_erl);

  // R8
  flush_src_chk: assert property (@(posedge clk) disable iff (rst)
    asid_flush |-> $past(op) == 3'd1);

  // R9
  ret_src_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(op) == 3'd2);

  // R9
  eret_erl_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2 && mode_erl) |=> (!mode_erl && $stable(mode_exl)));

  // R9
  eret_exl_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2 && !mode_erl) |=> (!mode_exl && !mode_erl));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_update |-> ($past(op) == 3'd1 || $past(op) == 3'd3 || $past(op) == 3'd4));

  // R11
  ri_src_chk: assert property (@(posedge clk) disable iff (rst)
    hw_ri |-> $past(op) == 3'd5);
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .op         (op),
  .ret_valid  (ret_valid),
  .hw_ri      (hw_ri),
  .mode_erl   (mode_erl),
  .mode_exl   (mode_exl),
  .asid_flush (asid_flush),
  .irq_update (irq_update)
);

// File: tb/tb_sysctl_regfile.sv
module tb_sysctl_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op = 3'd0;
  logic [4:0]  reg_num = '0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  hw_idx = '0;
  logic [31:0] cycle_cnt = 32'hCAFE_0001;
  logic        ll_load = 1'b0;
  logic [31:0] ll_addr = '0;
  logic [31:0] rd_data, ret_pc, old_status, hw_data;
  logic        ret_valid, hw_ri, mode_um, mode_erl, mode_exl, asid_flush, irq_update;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sysctl_regfile dut (
    .clk(clk), .rst(rst), .op(op), .reg_num(reg_num), .reg_sel(reg_sel),
    .wr_data(wr_data), .hw_idx(hw_idx), .cycle_cnt(cycle_cnt),
    .ll_load(ll_load), .ll_addr(ll_addr), .rd_data(rd_data), .ret_pc(ret_pc),
    .ret_valid(ret_valid), .old_status(old_status), .hw_data(hw_data),
    .hw_ri(hw_ri), .mode_um(mode_um), .mode_erl(mode_erl), .mode_exl(mode_exl),
    .asid_flush(asid_flush), .irq_update(irq_update)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [4:0] n, input logic [2:0] s,
                       input logic [31:0] d);
    op = o; reg_num = n; reg_sel = s; wr_data = d;
    @(negedge clk);
    op = 3'd0;
  endtask

  task automatic wr(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
    issue(3'd1, n, s, d);
  endtask

  task automatic rd(input logic [4:0] n, input logic [2:0] s, output logic [31:0] v);
    issue(3'd0, n, s, 32'd0);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'd12, 3'd0, v); chk("R1 status", v, 32'h0000_0004);
    rd(5'd15, 3'd1, v); chk("R1 base", v, 32'h8000_0000);
    rd(5'd13, 3'd0, v); chk("R1 cause", v, 32'h0);
    chk("R1 flags", {29'd0, mode_um, mode_erl, mode_exl}, 32'h2);
  endtask

  task automatic t_index();
    logic [31:0] v;
    wr(5'd0, 3'd0, 32'hFFFF_FFFF);
    rd(5'd0, 3'd0, v); chk("R2 index", v, 32'h0000_000F);
  endtask

  task automatic t_entry_page();
    logic [31:0] v;
    wr(5'd2, 3'd0, 32'hFFFF_FFFF);
    wr(5'd3, 3'd0, 32'hC000_1234);
    wr(5'd5, 3'd0, 32'hFFFF_FFFF);
    rd(5'd2, 3'd0, v); chk("R3 entry0", v, 32'h3FFF_FFFF);
    rd(5'd3, 3'd0, v); chk("R3 entry1", v, 32'h0000_1234);
    rd(5'd5, 3'd0, v); chk("R3 pagemask", v, 32'h1FFF_E000);
  endtask

  task automatic t_context();
    logic [31:0] v;
    wr(5'd4, 3'd0, 32'hFFFF_FFFF);
    rd(5'd4, 3'd0, v); chk("R4 context", v, 32'h007F_FFF0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    wr(5'd12, 3'd0, 32'hFFFF_FFFF);
    chk("R5 irq pulse", {31'd0, irq_update}, 32'd1);
    chk("R5 flags set", {29'd0, mode_um, mode_erl, mode_exl}, 32'h7);
    rd(5'd12, 3'd0, v); chk("R5 status view", v, 32'hFA78_FF17);
    wr(5'd12, 3'd0, 32'h0);
    rd(5'd12, 3'd0, v); chk("R5 status clear", v, 32'h0);
    chk("R5 flags clear", {29'd0, mode_um, mode_erl, mode_exl}, 32'h0);
  endtask

  task automatic t_cause();
    logic [31:0] v;
    wr(5'd13, 3'd0, 32'hFFFF_FFFF);
    chk("R6 irq on sw bits", {31'd0, irq_update}, 32'd1);
    rd(5'd13, 3'd0, v); chk("R6 cause", v, 32'h00C0_0300);
    wr(5'd13, 3'd0, 32'h00C0_0000);
    chk("R6 no irq", {31'd0, irq_update}, 32'd0);
    rd(5'd13, 3'd0, v); chk("R6 cause 2", v, 32'h00C0_0000);
  endtask

  task automatic t_base_misc();
    logic [31:0] v;
    wr(5'd15, 3'd1, 32'h0);
    rd(5'd15, 3'd1, v); chk("R7 base zero", v, 32'h8000_0000);
    wr(5'd15, 3'd1, 32'hFFFF_FFFF);
    rd(5'd15, 3'd1, v); chk("R7 base ones", v, 32'hBFFF_F000);
    wr(5'd7, 3'd0, 32'hFFFF_FFFF);
    rd(5'd7, 3'd0, v); chk("R7 hwen", v, 32'h0000_000F);
    wr(5'd12, 3'd1, 32'hFFFF_FFFF);
    rd(5'd12, 3'd1, v); chk("R7 intctl zero", v, 32'h0);
    wr(5'd12, 3'd3, 32'hFFFF_FFFF);
    rd(5'd12, 3'd3, v); chk("R7 srsmap zero", v, 32'h0);
  endtask

  task automatic t_asid();
    logic [31:0] v;
    wr(5'd10, 3'd0, 32'h1234_5FAB);
    chk("R8 flush on change", {31'd0, asid_flush}, 32'd1);
    rd(5'd10, 3'd0, v); chk("R8 entryhi", v, 32'h1234_40AB);
    wr(5'd10, 3'd0, 32'h0000_00AB);
    chk("R8 no flush same asid", {31'd0, asid_flush}, 32'd0);
  endtask

  task automatic t_eret();
    logic [31:0] v;
    wr(5'd12, 3'd0, 32'h0000_0006);
    wr(5'd14, 3'd0, 32'h0000_1000);
    wr(5'd30, 3'd0, 32'h0000_2000);
    ll_load = 1'b1; ll_addr = 32'h0000_0340;
    @(negedge clk);
    ll_load = 1'b0;
    rd(5'd17, 3'd0, v); chk("R12 lladdr shift", v, 32'h0000_0034);
    issue(3'd2, 5'd0, 3'd0, 32'd0);
    chk("R9 pc from error epc", ret_pc, 32'h0000_2000);
    chk("R9 valid", {31'd0, ret_valid}, 32'd1);
    chk("R9 erl cleared exl kept", {30'd0, mode_erl, mode_exl}, 32'h1);
    rd(5'd17, 3'd0, v); chk("R9 lladdr one", v, 32'h0);
    issue(3'd2, 5'd0, 3'd0, 32'd0);
    chk("R9 pc from epc", ret_pc, 32'h0000_1000);
    chk("R9 exl cleared", {30'd0, mode_erl, mode_exl}, 32'h0);
  endtask

  task automatic t_intr();
    logic [31:0] v;
    issue(3'd4, 5'd0, 3'd0, 32'd0);
    chk("R10 enable old", old_status, 32'h0);
    chk("R10 enable irq", {31'd0, irq_update}, 32'd1);
    rd(5'd12, 3'd0, v); chk("R10 ie set", v, 32'h1);
    issue(3'd3, 5'd0, 3'd0, 32'd0);
    chk("R10 disable old", old_status, 32'h1);
    rd(5'd12, 3'd0, v); chk("R10 ie clear", v, 32'h0);
  endtask

  task automatic t_hwr();
    wr(5'd7, 3'd0, 32'h0);
    hw_idx = 2'd2; issue(3'd5, 5'd0, 3'd0, 32'd0);
    chk("R11 refused", {31'd0, hw_ri}, 32'd1);
    chk("R11 refused data", hw_data, 32'h0);
    wr(5'd7, 3'd0, 32'h5);
    hw_idx = 2'd2; issue(3'd5, 5'd0, 3'd0, 32'd0);
    chk("R11 cycles", hw_data, 32'hCAFE_0001);
    chk("R11 cycles ok", {31'd0, hw_ri}, 32'd0);
    hw_idx = 2'd1; issue(3'd5, 5'd0, 3'd0, 32'd0);
    chk("R11 synci refused", {31'd0, hw_ri}, 32'd1);
    hw_idx = 2'd0; issue(3'd5, 5'd0, 3'd0, 32'd0);
    chk("R11 cpu num", hw_data, 32'h0);
    chk("R11 cpu num ok", {31'd0, hw_ri}, 32'd0);
    wr(5'd7, 3'd0, 32'hA);
    hw_idx = 2'd1; issue(3'd5, 5'd0, 3'd0, 32'd0);
    chk("R11 synci", hw_data, 32'd32);
    hw_idx = 2'd3; issue(3'd5, 5'd0, 3'd0, 32'd0);
    chk("R11 resolution", hw_data, 32'd2);
    hw_idx = 2'd0; issue(3'd5, 5'd0, 3'd0, 32'd0);
    chk("R11 cpu refused", {31'd0, hw_ri}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_index();
    t_entry_page();
    t_context();
    t_status();
    t_cause();
    t_base_misc();
    t_asid();
    t_eret();
    t_intr();
    t_hwr();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule